// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Model

This block is a cycle-accurate, synthesizable model of a synchronous static RAM whose late-write timing lets reads and writes follow each other on every clock with no idle cycle between them. Address, control and write data are captured on the rising clock edge. The data word is made of 9-bit byte lanes, and each lane has its own active-low write enable. A static mode input picks one of two timings. In pipelined timing, read data passes through an output register and write data follows its address by two cycles. In flow-through timing, read data is driven straight from the array and write data follows by one cycle.

A command is loaded when the burst-continue input is low and all three select inputs are active. With burst-continue high, a 2-bit counter steps the two low address bits in linear or interleaved order and repeats the last command type. An active-low clock enable freezes all internal state. An asynchronous output enable gates the read port. The bidirectional bus is split into a data input, a data output and a drive-enable output. Reset loads a computed pattern into the array so that the bench can predict every word.

Top module: `nbt_sram`

## Requirements
- R1: During reset the output is not driven (`dout_en` = 0, `dout` = 0). Reset loads each word i with the low DATA_W bits of (i*40503) XOR 1445. Within a word, lane g occupies bits g*BYTE_W and up.
- R2: With `flow_n` high (pipelined), a read loaded at edge k drives its data, with `dout_en` high, in the cycle that follows edge k+1. `dout_en` is high only in cycles that carry read data.
- R3: With `flow_n` low (flow-through), a read loaded at edge k drives its data in the cycle that follows edge k itself.
- R4: Write data is sampled from `din` at the second enabled edge after its address in pipelined timing, and at the first enabled edge after it in flow-through timing.
- R5: A lane is written only when its `be_n` bit is 0. A write with every `be_n` bit at 1 leaves the word unchanged.
- R6: Reads and writes may follow one another in any order on consecutive cycles. A read always returns the latest written data, including data whose write is sampled at the same edge that registers the read.
- R7: When `burst_cont` is high after a load, the command type repeats and a 2-bit count n advances. The two low address bits become base+n mod 4 when `lin_burst_n` = 0, or base XOR n when `lin_burst_n` = 1. The upper address bits stay fixed.
- R8: When a load cycle has any select inactive (`sel_a_n` = 1, `sel_b` = 0 or `sel_c_n` = 1), no operation starts. Any following burst-continue cycles also do nothing until the next successful load.
- R9: While `clk_en_n` is high, no state changes. The output holds its value, and a pending write waits for the next enabled edge to take its data.
- R10: `oe_n` high forces `dout_en` to 0 and `dout` to 0 at once, without a clock edge. Returning `oe_n` low restores the pending output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the array pattern |
| flow_n | input | 1 | Static mode: 0 flow-through, 1 pipelined |
| lin_burst_n | input | 1 | Static burst order: 0 linear, 1 interleaved |
| clk_en_n | input | 1 | Active-low clock enable |
| sel_a_n | input | 1 | Active-low select |
| sel_b | input | 1 | Active-high select |
| sel_c_n | input | 1 | Active-low select |
| we_n | input | 1 | 0 write, 1 read, sampled on load cycles |
| burst_cont | input | 1 | 0 load a new command, 1 continue the burst |
| be_n | input | BYTES | Active-low lane write enables |
| addr | input | ADDR_W | Word address |
| din | input | BYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | BYTES*BYTE_W | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` carries read data |

## Verification
On every cycle, the assertions check the following:
- the command register and the output register hold still under a disabled clock;
- a deselected load keeps later burst-continue cycles idle;
- each linear burst step moves the low address bits by one and keeps the upper bits and the command type;
- a pipelined read is followed by a driven output;
- a pipelined write's data is sampled at the second enabled edge.

Only the bench scenarios can show that the data is correct, because that needs a reference array. These scenarios cover lane merging, forwarding of a write whose data is sampled at the same edge that registers a read, and the interleaved order. They also cover writes held over suspended cycles and the asynchronous output enable, which has no clock to sample against.

// File: rtl/nbt_sram_pkg.sv
`timescale 1ns/1ps
package nbt_sram_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // low two address bits of burst step 'step' starting at 'base'
    function automatic logic [1:0] burst_slot(input logic [1:0] base,
                                              input logic [1:0] step,
                                              input logic       interleave);
        return interleave ? (base ^ step) : (base + step);
    endfunction

    // array content loaded by reset
    function automatic logic [63:0] init_word(input int unsigned idx);
        return 64'((idx * 32'd40503) ^ 32'd1445);
    endfunction

endpackage

// File: rtl/nbt_cmd_decode.sv
`timescale 1ns/1ps
module nbt_cmd_decode
    import nbt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              we_n,
    input  logic              burst_cont,
    input  logic              lin_burst_n,
    input  logic [BYTES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              s1_valid,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [BYTES-1:0]  s1_be_n
);

    typedef struct packed {
        logic              active;
        op_e               op;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic              s1_valid;
        op_e               s1_op;
        logic [ADDR_W-1:0] s1_addr;
        logic [BYTES-1:0]  s1_be_n;
    } cmd_state_t;

    cmd_state_t st_d, st_q;
    logic       selected;
    logic [1:0] cnt_nx;

    always_comb begin
        selected = !sel_a_n && sel_b && !sel_c_n;
        cnt_nx   = st_q.cnt + 2'd1;
        st_d     = st_q;
        if (!clk_en_n) begin
            if (!burst_cont) begin
                if (selected) begin
                    st_d.active   = 1'b1;
                    st_d.op       = we_n ? OP_READ : OP_WRITE;
                    st_d.base     = addr;
                    st_d.cnt      = 2'd0;
                    st_d.s1_valid = 1'b1;
                    st_d.s1_op    = we_n ? OP_READ : OP_WRITE;
                    st_d.s1_addr  = addr;
                    st_d.s1_be_n  = be_n;
                end else begin
                    st_d.active   = 1'b0;
                    st_d.s1_valid = 1'b0;
                end
            end else if (st_q.active) begin
                st_d.cnt      = cnt_nx;
                st_d.s1_valid = 1'b1;
                st_d.s1_op    = st_q.op;
                st_d.s1_addr  = {st_q.base[ADDR_W-1:2],
                                 burst_slot(st_q.base[1:0], cnt_nx, lin_burst_n)};
                st_d.s1_be_n  = be_n;
            end else begin
                st_d.s1_valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_valid = st_q.s1_valid;
    assign s1_op    = st_q.s1_op;
    assign s1_addr  = st_q.s1_addr;
    assign s1_be_n  = st_q.s1_be_n;

    // R9: a disabled clock freezes the command stage
    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(st_q))
        else $error("command stage changed while clock disabled");

    // R8: a failed load leaves following continue cycles idle
    assert_desel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !burst_cont && !selected) ##1 (!clk_en_n && burst_cont)
        |=> !s1_valid)
        else $error("burst continued after deselect");

    // R7: linear burst step
    assert_burst_linear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && burst_cont && st_q.active && !lin_burst_n)
        |=> s1_valid
            && (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1)
            && (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]))
            && (s1_op == $past(s1_op)))
        else $error("linear burst step wrong");

endmodule

// File: rtl/nbt_mem_array.sv
`timescale 1ns/1ps
module nbt_mem_array
    import nbt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BYTES-1:0]        wr_be_n,
    input  logic [BYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [BYTES*BYTE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int unsigned i = 0; i < DEPTH; i++)
                    lane_q[ADDR_W'(i)] <= BYTE_W'(init_word(i) >> (g * BYTE_W));
            end else if (wr_en && !wr_be_n[g]) begin
                lane_q[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[g*BYTE_W +: BYTE_W] = lane_q[rd_addr];
    end

endmodule

// File: rtl/nbt_data_path.sv
`timescale 1ns/1ps
module nbt_data_path
    import nbt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    flow_n,
    input  logic                    oe_n,
    input  logic                    s1_valid,
    input  op_e                     s1_op,
    input  logic [ADDR_W-1:0]       s1_addr,
    input  logic [BYTES-1:0]        s1_be_n,
    input  logic [BYTES*BYTE_W-1:0] din,
    input  logic [BYTES*BYTE_W-1:0] rd_data,
    output logic                    wr_en,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [BYTES-1:0]        wr_be_n,
    output logic [BYTES*BYTE_W-1:0] wr_data,
    output logic [BYTES*BYTE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W = BYTES * BYTE_W;

    typedef struct packed {
        logic              s2_valid;
        op_e               s2_op;
        logic [ADDR_W-1:0] s2_addr;
        logic [BYTES-1:0]  s2_be_n;
        logic              oreg_v;
        logic [DATA_W-1:0] oreg_data;
    } path_state_t;

    path_state_t st_d, st_q;
    logic              c_valid, fwd, rd_live;
    op_e               c_op;
    logic [DATA_W-1:0] merged, data_live;

    always_comb begin
        // commit slot: one stage late in flow-through, two in pipelined
        if (!flow_n) begin
            c_valid = s1_valid;
            c_op    = s1_op;
            wr_addr = s1_addr;
            wr_be_n = s1_be_n;
        end else begin
            c_valid = st_q.s2_valid;
            c_op    = st_q.s2_op;
            wr_addr = st_q.s2_addr;
            wr_be_n = st_q.s2_be_n;
        end
        wr_en   = !clk_en_n && c_valid && (c_op == OP_WRITE);
        wr_data = din;

        // merge data being written at this edge into the word being read
        fwd    = wr_en && (wr_addr == s1_addr);
        merged = rd_data;
        for (int g = 0; g < BYTES; g++)
            if (fwd && !wr_be_n[g]) merged[g*BYTE_W +: BYTE_W] = din[g*BYTE_W +: BYTE_W];

        st_d = st_q;
        if (!clk_en_n) begin
            st_d.s2_valid  = s1_valid;
            st_d.s2_op     = s1_op;
            st_d.s2_addr   = s1_addr;
            st_d.s2_be_n   = s1_be_n;
            st_d.oreg_v    = s1_valid && (s1_op == OP_READ);
            st_d.oreg_data = merged;
        end

        rd_live   = flow_n ? st_q.oreg_v : (s1_valid && (s1_op == OP_READ));
        data_live = flow_n ? st_q.oreg_data : merged;
        dout_en   = rd_live && !oe_n;
        dout      = dout_en ? data_live : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: output register and late-write stage hold under a disabled clock
    assert_path_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(st_q))
        else $error("data path changed while clock disabled");

    // R2: pipelined read is driven in the following cycle
    assert_pipe_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && flow_n && s1_valid && s1_op == OP_READ) |=> (dout_en || oe_n))
        else $error("pipelined read not driven");

    // R4: pipelined write takes its data at the second enabled edge
    assert_pipe_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && flow_n && s1_valid && s1_op == OP_WRITE) ##1 !clk_en_n
        |-> wr_en && (wr_addr == $past(s1_addr)))
        else $error("pipelined write missed its data slot");

endmodule

// File: rtl/nbt_sram.sv
`timescale 1ns/1ps
module nbt_sram
    import nbt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flow_n,
    input  logic                    lin_burst_n,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    we_n,
    input  logic                    burst_cont,
    input  logic [BYTES-1:0]        be_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES*BYTE_W-1:0] din,
    input  logic                    oe_n,
    output logic [BYTES*BYTE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W = BYTES * BYTE_W;

    logic              s1_valid;
    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [BYTES-1:0]  s1_be_n;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTES-1:0]  wr_be_n;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    nbt_cmd_decode #(.ADDR_W(ADDR_W), .BYTES(BYTES)) cmd_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_en_n    (clk_en_n),
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .we_n        (we_n),
        .burst_cont  (burst_cont),
        .lin_burst_n (lin_burst_n),
        .be_n        (be_n),
        .addr        (addr),
        .s1_valid    (s1_valid),
        .s1_op       (s1_op),
        .s1_addr     (s1_addr),
        .s1_be_n     (s1_be_n)
    );

    nbt_mem_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_be_n (wr_be_n),
        .wr_data (wr_data),
        .rd_addr (s1_addr),
        .rd_data (rd_data)
    );

    nbt_data_path #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) path_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_n (clk_en_n),
        .flow_n   (flow_n),
        .oe_n     (oe_n),
        .s1_valid (s1_valid),
        .s1_op    (s1_op),
        .s1_addr  (s1_addr),
        .s1_be_n  (s1_be_n),
        .din      (din),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_be_n  (wr_be_n),
        .wr_data  (wr_data),
        .dout     (dout),
        .dout_en  (dout_en)
    );

endmodule

// File: tb/nbt_sram_tb_top.sv
`timescale 1ns/1ps
module nbt_sram_tb_top;

    localparam int ADDR_W = 8;
    localparam int BYTES  = 2;
    localparam int BYTE_W = 9;
    localparam int DATA_W = BYTES * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    logic              rst_n = 1'b0;
    logic              flow_n = 1'b1, lin_burst_n = 1'b0, clk_en_n = 1'b0;
    logic              sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
    logic              we_n = 1'b1, burst_cont = 1'b0, oe_n = 1'b0;
    logic [BYTES-1:0]  be_n = '1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_en;

    nbt_sram #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .flow_n(flow_n), .lin_burst_n(lin_burst_n),
        .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .we_n(we_n), .burst_cont(burst_cont), .be_n(be_n), .addr(addr), .din(din),
        .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
    );

    typedef struct {
        bit                v;
        bit                wr;
        logic [ADDR_W-1:0] a;
        logic [BYTES-1:0]  be;
    } hcmd_t;

    logic [DATA_W-1:0] mm [DEPTH];
    bit                m_act, m_wr;
    logic [ADDR_W-1:0] m_base;
    logic [1:0]        m_cnt;
    hcmd_t             h1, h2;
    bit                exp_en;
    logic [DATA_W-1:0] exp_data;
    int                n_tests = 0, n_fail = 0;
    bit                done = 0;

    function automatic logic [DATA_W-1:0] seed_word(input int unsigned i);
        return DATA_W'((i * 40503) ^ 1445);
    endfunction

    task automatic check(input string tag, input logic [DATA_W-1:0] act_d, input logic act_e,
                         input logic [DATA_W-1:0] exp_d, input logic exp_e);
        n_tests++;
        if (act_d !== exp_d || act_e !== exp_e) begin
            n_fail++;
            $display("FAIL %s: dout=%h dout_en=%b expected dout=%h dout_en=%b",
                     tag, act_d, act_e, exp_d, exp_e);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) mm[i] = seed_word(i);
        h1 = '{default: 0};
        h2 = '{default: 0};
        m_act = 0; m_wr = 0; m_base = '0; m_cnt = '0;
        exp_en = 0; exp_data = '0;
    endtask

    task automatic model_edge();
        hcmd_t due, cur, r;
        logic [1:0] lo;
        due = flow_n ? h2 : h1;
        if (due.v && due.wr)
            for (int g = 0; g < BYTES; g++)
                if (!due.be[g]) mm[due.a][g*BYTE_W +: BYTE_W] = din[g*BYTE_W +: BYTE_W];
        cur = '{default: 0};
        if (!burst_cont) begin
            if (!sel_a_n && sel_b && !sel_c_n) begin
                m_act = 1; m_wr = !we_n; m_base = addr; m_cnt = 2'd0;
                cur.v = 1; cur.wr = !we_n; cur.a = addr; cur.be = be_n;
            end else m_act = 0;
        end else if (m_act) begin
            m_cnt = m_cnt + 2'd1;
            lo = lin_burst_n ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
            cur.v = 1; cur.wr = m_wr; cur.a = {m_base[ADDR_W-1:2], lo}; cur.be = be_n;
        end
        h2 = h1;
        h1 = cur;
        r = flow_n ? h2 : h1;
        exp_en = r.v && !r.wr;
        if (exp_en) exp_data = mm[r.a];
    endtask

    // one clock: model update at the edge, compare away from it
    task automatic step(input string tag);
        @(posedge clk);
        if (!clk_en_n) model_edge();
        @(negedge clk);
        check(tag, dout, dout_en, (exp_en && !oe_n) ? exp_data : '0, exp_en && !oe_n);
    endtask

    task automatic set_nop();
        clk_en_n = 0; burst_cont = 0; sel_a_n = 1; sel_b = 1; sel_c_n = 0; we_n = 1; be_n = '1;
    endtask
    task automatic set_rd(input logic [ADDR_W-1:0] a);
        clk_en_n = 0; burst_cont = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0; we_n = 1; addr = a;
    endtask
    task automatic set_wr(input logic [ADDR_W-1:0] a, input logic [BYTES-1:0] b);
        clk_en_n = 0; burst_cont = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0; we_n = 0; addr = a; be_n = b;
    endtask
    task automatic set_cont(input logic [BYTES-1:0] b);
        clk_en_n = 0; burst_cont = 1; be_n = b;
    endtask

    task automatic do_reset(input logic fl_n, input logic lb_n);
        set_nop();
        flow_n = fl_n; lin_burst_n = lb_n; oe_n = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        check("R1", dout, dout_en, '0, 1'b0);
        rst_n = 1;
        model_reset();
    endtask

    task automatic random_run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            clk_en_n   = ($urandom % 10) == 0;
            burst_cont = ($urandom % 3) == 0;
            sel_a_n    = ($urandom % 12) == 0;
            sel_b      = ($urandom % 12) != 0;
            sel_c_n    = ($urandom % 12) == 0;
            we_n       = $urandom % 2;
            be_n       = BYTES'($urandom);
            addr       = ADDR_W'($urandom % 16);
            din        = DATA_W'($urandom);
            oe_n       = ($urandom % 12) == 0;
            step("R6");
        end
        oe_n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R6: watchdog expired, actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd91357));

        // ---- pipelined, linear ----
        do_reset(1'b1, 1'b0);
        set_rd(8'd3);  step("R2");
        set_nop();     step("R2");
        check("R1", dout, dout_en, seed_word(3), 1'b1);
        // R10: asynchronous output enable
        oe_n = 1; #1;
        check("R10", dout, dout_en, '0, 1'b0);
        oe_n = 0; #1;
        check("R10", dout, dout_en, seed_word(3), 1'b1);
        // R9: output held while suspended
        clk_en_n = 1; step("R9"); step("R9");
        check("R9", dout, dout_en, seed_word(3), 1'b1);
        set_nop();     step("R2");

        // R4/R6: write then read same word back to back, data sampled at read's register edge
        set_wr(8'd10, 2'b00); din = 18'h3FFFF; step("R4");
        set_rd(8'd10);        din = 18'h3FFFF; step("R4");
        set_nop();            din = 18'h12345; step("R6");
        check("R6", dout, dout_en, 18'h12345, 1'b1);
        set_nop(); step("R4");

        // R5: lane merge and write abort
        set_wr(8'd20, 2'b10); step("R5");
        set_wr(8'd21, 2'b11); step("R5");
        set_rd(8'd20); din = 18'h2AAAA; step("R5");
        set_rd(8'd21); din = 18'h15555; step("R5");
        check("R5", dout, dout_en, {seed_word(20)[17:9], 9'h0AA}, 1'b1);
        set_nop(); step("R5");
        check("R5", dout, dout_en, seed_word(21), 1'b1);

        // R7: linear read burst from 6 -> 6,7,4,5
        set_rd(8'd6); step("R7");
        set_cont('1); step("R7"); step("R7"); step("R7");
        set_nop(); step("R7");
        check("R7", dout, dout_en, seed_word(5), 1'b1);

        // R8: deselected load then continue -> nothing, even a write
        set_wr(8'd40, 2'b00); sel_b = 0; step("R8");
        set_cont(2'b00); din = 18'h0BEEF; step("R8");
        check("R8", dout, dout_en, '0, 1'b0);
        step("R8");
        set_rd(8'd40); step("R8");
        set_nop(); step("R8");
        check("R8", dout, dout_en, seed_word(40), 1'b1);

        // R9: pending write waits over suspended edges
        set_wr(8'd50, 2'b00); din = '0; step("R9");
        set_nop(); step("R9");
        clk_en_n = 1; din = 18'h3C3C3; step("R9"); step("R9");
        set_nop(); din = 18'h1A5A5; step("R9");
        set_rd(8'd50); step("R9");
        set_nop(); step("R9");
        check("R9", dout, dout_en, 18'h1A5A5, 1'b1);

        random_run(1500);

        // ---- flow-through, interleaved ----
        do_reset(1'b0, 1'b1);
        set_rd(8'd7); step("R3");
        check("R3", dout, dout_en, seed_word(7), 1'b1);
        set_wr(8'd30, 2'b00); step("R4");
        set_rd(8'd30); din = 18'h2D2D2; step("R4");
        check("R4", dout, dout_en, 18'h2D2D2, 1'b1);
        // R7: interleaved burst from 9 -> 9,8,11,10
        set_rd(8'd9); step("R7");
        set_cont('1); step("R7");
        check("R7", dout, dout_en, seed_word(8), 1'b1);
        step("R7");
        check("R7", dout, dout_en, seed_word(11), 1'b1);
        step("R7");
        check("R7", dout, dout_en, seed_word(10), 1'b1);
        set_nop(); step("R3");

        random_run(1500);

        do_reset(1'b1, 1'b1);
        random_run(1500);
        do_reset(1'b0, 1'b0);
        random_run(1500);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule